// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block sequences the control strobes for one external peripheral bank, one access at a time. A request carries an address, a read/write flag, byte lanes, write data, a burst flag and a beat count. It is accepted over a valid/ready handshake together with a 32-bit timing word that holds the bank's settings. The sequencer then walks the access through its phases: an address lead, one or more data beats with chip select held, and a post-transfer hold. It places every strobe edge at its own programmed offset and emits a one-cycle capture strobe on each data transfer cycle.

The request interface has no buffering. `req_ready_o` is high only while the block is idle. A request is taken on the rising edge where `req_valid_i` and `req_ready_o` are both high, and the requester must hold its fields stable until then. While an access is in flight `req_ready_o` stays low, so the requester sees back-pressure for the whole access, hold phase included.

An optional ready handshake with the device can stretch each beat. The configuration picks whether data moves on the clock where ready is seen or one clock later. A timeout can bound the wait. When it expires, the access is cut short through the hold phase, a one-cycle error pulse is raised, and the failing address and direction are kept until software clears them. A combinational flag reports timing words that break the programming rules.

Top module: `ebus_seq`

## Requirements
- R1: `req_ready_o` is 1 only when idle. A request is accepted on the edge where `req_valid_i` and `req_ready_o` are both 1, and the timing word is sampled on that edge. `addr_phase_o` is 1 from the first cycle after acceptance until the last hold cycle, and `req_ready_o` is 0 for that whole time.
- R2: The timing word is numbered with bit 0 as its most significant bit. The fields are: wait count BW in bits 6:8, chip-select delay CD in bits 12:13, read-strobe delay OD in 14:15, lane-strobe delay LD in 16:17, lane-strobe advance LA in 18:19, hold count HC in 20:22, ready enable RE in 23, same-edge sampling SE in 24 and lane mode LM in 25. In the usual LSB-0 numbering these are [25:23], [19:18], [17:16], [15:14], [13:12], [11:9], [8], [7] and [6].
- R3: `cs_o` first rises CD cycles after the first address-valid cycle. If the first cycle after acceptance is cycle 0, chip select is first high in cycle CD.
- R4: On reads, `oe_o` rises OD cycles after `cs_o` rises and stays high while chip select does. On writes, `oe_o` stays 0.
- R5: `wbe_o` carries the request's lanes from LD cycles after `cs_o` rises. On writes it is always driven. On reads it is driven only when LM=1, and with LM=0 it stays 0 on reads.
- R6: On the last beat, `wbe_o` drops LA cycles before `cs_o` drops. With LA=0 both drop together.
- R7: Each beat lasts 1+BW cycles when ready pacing does not stretch it, and chip select stays high across all beats of a burst. With the burst flag set, `req_beats_i` is the beat count minus one. `bus_addr_o` advances by the lane count (4) at each new beat. With the burst flag clear the access has exactly one beat.
- R8: After chip select drops, `hold_phase_o` is 1 for HC cycles. During those cycles the address stays valid and `cs_o`, `oe_o` and `wbe_o` are 0.
- R9: With RE=0, `rdy_i` is ignored and `cap_o` is 1 on the last cycle of every beat.
- R10: With RE=1, `rdy_i` is first looked at in the last programmed cycle of a beat. Each cycle in which it is 0 adds a wait cycle with chip select held. With SE=1, `cap_o` is 1 in the cycle where `rdy_i` is seen high. With SE=0, `cap_o` is 1 in the following cycle. The beat ends with the capture cycle.
- R11: With `tmo_en_i`=0 the block waits for ready without limit. With `tmo_en_i`=1 the access ends after `tmo_limit_i` added wait cycles (0 acts as 1); chip select drops and the hold phase follows. In the next cycle `err_pulse_o` is 1 for exactly one cycle, `err_valid_o` is set, `err_addr_o` holds the beat's address, and `err_wr_o` is 1 for a write and 0 for a read.
- R12: `err_valid_o`, `err_addr_o` and `err_wr_o` keep their values until `err_clr_i` is sampled high, and `err_clr_i` clears `err_valid_o` on the next edge.
- R13: `cfg_err_o` is 1 when any of these holds for `cfg_word_i`: LA > BW; RE=1 with LA not 0; RE=1 and SE=1 with HC=0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_addr_i | input | 32 | Access start address |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_be_i | input | 4 | Byte lanes of the access |
| req_wdata_i | input | 32 | Write data |
| req_burst_i | input | 1 | Burst enable |
| req_beats_i | input | 4 | Beat count minus one (burst only) |
| cfg_word_i | input | 32 | Bank timing word |
| rdy_i | input | 1 | Device ready |
| tmo_en_i | input | 1 | Ready timeout enable |
| tmo_limit_i | input | 8 | Added wait cycles allowed |
| err_clr_i | input | 1 | Clears the error record |
| bus_addr_o | output | 32 | Bus address |
| bus_wr_o | output | 1 | Bus direction, 1 = write |
| bus_wdata_o | output | 32 | Bus write data |
| cs_o | output | 1 | Chip select (active high) |
| oe_o | output | 1 | Read output enable (active high) |
| wbe_o | output | 4 | Lane strobes (active high) |
| addr_phase_o | output | 1 | Address valid phase |
| hold_phase_o | output | 1 | Post-transfer hold phase |
| cap_o | output | 1 | Data transfer cycle strobe |
| err_pulse_o | output | 1 | One-cycle timeout pulse |
| err_valid_o | output | 1 | Error record valid |
| err_addr_o | output | 32 | Address of timed-out beat |
| err_wr_o | output | 1 | Direction of timed-out beat |
| cfg_err_o | output | 1 | Illegal timing word |

## Verification
A wrong beat or lead counter shows within the same access as a chip-select window of the wrong length or position, a missing or doubled capture strobe, or a burst address that steps early or late. Each of these appears at most 1+BW cycles after the slip. A stale latched timing word or a lane-strobe offset error moves a strobe edge by whole cycles relative to chip select, so the bench measures each edge index against the programmed field. A faulty wait or timeout counter either holds chip select too long or times out too early. Either one changes the capture index or the error pulse cycle in that very access. A lost error record shows on the next idle cycles as a dropped `err_valid_o` or a changed `err_addr_o`.

// File: rtl/ebus_seq_pkg.sv
`timescale 1ns/1ps
package ebus_seq_pkg;

  localparam int CFG_W   = 32;
  // LSB-0 positions of the timing fields (MSB-0 bits 6:8, 12:13, 14:15,
  // 16:17, 18:19, 20:22, 23, 24, 25)
  localparam int BW_LSB  = 23;
  localparam int CD_LSB  = 18;
  localparam int OD_LSB  = 16;
  localparam int LD_LSB  = 14;
  localparam int LA_LSB  = 12;
  localparam int HC_LSB  = 9;
  localparam int RE_POS  = 8;
  localparam int SE_POS  = 7;
  localparam int LM_POS  = 6;

  typedef struct packed {
    logic [2:0] bw;   // wait cycles per beat beyond the first
    logic [1:0] cd;   // chip-select delay after address
    logic [1:0] od;   // read strobe delay after chip select
    logic [1:0] ld;   // lane strobe delay after chip select
    logic [1:0] la;   // lane strobe advance before chip select drop
    logic [2:0] hc;   // hold cycles
    logic       re;   // ready pacing enable
    logic       se;   // transfer on ready edge
    logic       lm;   // lane strobes on reads too
  } tcfg_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LEAD  = 3'd1,
    S_BEAT  = 3'd2,
    S_RWAIT = 3'd3,
    S_RLATE = 3'd4,
    S_HOLD  = 3'd5
  } seq_st_t;

endpackage

// File: rtl/ebus_cfg_unpack.sv
`timescale 1ns/1ps
module ebus_cfg_unpack
  import ebus_seq_pkg::*;
(
  input  logic [CFG_W-1:0] word_i,
  output tcfg_t            cfg_o,
  output logic             err_o
);

  always_comb begin
    cfg_o.bw = word_i[BW_LSB +: 3];
    cfg_o.cd = word_i[CD_LSB +: 2];
    cfg_o.od = word_i[OD_LSB +: 2];
    cfg_o.ld = word_i[LD_LSB +: 2];
    cfg_o.la = word_i[LA_LSB +: 2];
    cfg_o.hc = word_i[HC_LSB +: 3];
    cfg_o.re = word_i[RE_POS];
    cfg_o.se = word_i[SE_POS];
    cfg_o.lm = word_i[LM_POS];
  end

  logic adv_too_big, adv_with_rdy, no_hold_same_edge;

  assign adv_too_big       = {1'b0, cfg_o.la} > cfg_o.bw;
  assign adv_with_rdy      = cfg_o.re && (cfg_o.la != 2'd0);
  assign no_hold_same_edge = cfg_o.re && cfg_o.se && (cfg_o.hc == 3'd0);
  assign err_o = adv_too_big || adv_with_rdy || no_hold_same_edge;

  logic unused_bits;
  assign unused_bits = ^{word_i[31:26], word_i[22:20], word_i[5:0]};

endmodule

// File: rtl/ebus_seq_fsm.sv
`timescale 1ns/1ps
module ebus_seq_fsm
  import ebus_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int BEAT_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_burst_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  tcfg_t             cfg_i,
  input  logic              rdy_i,
  input  logic              tmo_en_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output seq_st_t           st_o,
  output logic [2:0]        cnt_o,
  output logic              last_beat_o,
  output logic [1:0]        cs_age_o,
  output tcfg_t             lcfg_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              cap_o,
  output logic              tmo_hit_o
);

  localparam int                TW   = TMO_W + 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BE_W);

  seq_st_t           st;
  tcfg_t             lcfg;
  logic [2:0]        cnt;
  logic [2:0]        hcnt;
  logic [1:0]        lcnt;
  logic [1:0]        cs_age;
  logic [BEAT_W-1:0] left;
  logic [TMO_W-1:0]  tcnt;
  logic [ADDR_W-1:0] addr;
  logic              wr;
  logic [BE_W-1:0]   be;
  logic [DATA_W-1:0] wdata;

  logic    in_cs, wait_end, xfer, tmo_hit;
  seq_st_t end_st;

  assign in_cs    = (st == S_BEAT) || (st == S_RWAIT) || (st == S_RLATE);
  assign wait_end = (st == S_BEAT) && (cnt == lcfg.bw);
  assign xfer     = (wait_end && (!lcfg.re || (rdy_i && lcfg.se)))
                 || ((st == S_RWAIT) && rdy_i && lcfg.se)
                 || (st == S_RLATE);
  assign tmo_hit  = (st == S_RWAIT) && !rdy_i && tmo_en_i
                 && ((TW'(tcnt) + TW'(1)) >= TW'(tmo_limit_i));
  assign end_st   = (lcfg.hc != 3'd0) ? S_HOLD : S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lcfg   <= '0;
      cnt    <= '0;
      hcnt   <= '0;
      lcnt   <= '0;
      cs_age <= '0;
      left   <= '0;
      tcnt   <= '0;
      addr   <= '0;
      wr     <= 1'b0;
      be     <= '0;
      wdata  <= '0;
    end else begin
      if (in_cs && cs_age != 2'd3) cs_age <= cs_age + 2'd1;
      case (st)
        S_IDLE: begin
          if (req_valid_i) begin
            lcfg   <= cfg_i;
            addr   <= req_addr_i;
            wr     <= req_wr_i;
            be     <= req_be_i;
            wdata  <= req_wdata_i;
            left   <= req_burst_i ? req_beats_i : '0;
            cnt    <= '0;
            lcnt   <= '0;
            cs_age <= '0;
            st     <= (cfg_i.cd != 2'd0) ? S_LEAD : S_BEAT;
          end
        end
        S_LEAD: begin
          lcnt <= lcnt + 2'd1;
          if (lcnt == lcfg.cd - 2'd1) st <= S_BEAT;
        end
        S_BEAT: begin
          if (!wait_end) begin
            cnt <= cnt + 3'd1;
          end else if (!xfer) begin
            if (rdy_i) begin
              st <= S_RLATE;
            end else begin
              st   <= S_RWAIT;
              tcnt <= '0;
            end
          end
        end
        S_RWAIT: begin
          if (tmo_hit) begin
            st   <= end_st;
            hcnt <= '0;
          end else if (!xfer) begin
            if (rdy_i) st <= S_RLATE;
            else       tcnt <= tcnt + TMO_W'(1);
          end
        end
        S_RLATE: ;
        S_HOLD: begin
          hcnt <= hcnt + 3'd1;
          if (hcnt == lcfg.hc - 3'd1) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      // a data transfer closes the current beat
      if (xfer) begin
        if (left != '0) begin
          left <= left - BEAT_W'(1);
          addr <= addr + STEP;
          cnt  <= '0;
          st   <= S_BEAT;
        end else begin
          st   <= end_st;
          hcnt <= '0;
        end
      end
    end
  end

  assign req_ready_o = (st == S_IDLE);
  assign st_o        = st;
  assign cnt_o       = cnt;
  assign last_beat_o = (left == '0);
  assign cs_age_o    = cs_age;
  assign lcfg_o      = lcfg;
  assign addr_o      = addr;
  assign wr_o        = wr;
  assign be_o        = be;
  assign wdata_o     = wdata;
  assign cap_o       = xfer;
  assign tmo_hit_o   = tmo_hit;

endmodule

// File: rtl/ebus_strobe_gen.sv
`timescale 1ns/1ps
module ebus_strobe_gen
  import ebus_seq_pkg::*;
#(
  parameter int BE_W = 4
) (
  input  seq_st_t         st_i,
  input  logic [2:0]      cnt_i,
  input  logic            last_beat_i,
  input  logic [1:0]      cs_age_i,
  input  tcfg_t           cfg_i,
  input  logic            wr_i,
  input  logic [BE_W-1:0] be_i,
  output logic            cs_o,
  output logic            oe_o,
  output logic [BE_W-1:0] wbe_o,
  output logic            addr_phase_o,
  output logic            hold_phase_o
);

  logic [3:0] beat_len;
  logic       lane_early_off, lane_on;

  assign cs_o         = (st_i == S_BEAT) || (st_i == S_RWAIT) || (st_i == S_RLATE);
  assign addr_phase_o = (st_i != S_IDLE);
  assign hold_phase_o = (st_i == S_HOLD);
  assign oe_o         = cs_o && !wr_i && (cs_age_i >= cfg_i.od);

  assign beat_len       = {1'b0, cfg_i.bw} + 4'd1;
  assign lane_early_off = (cfg_i.la != 2'd0) && last_beat_i && (st_i == S_BEAT)
                       && (({1'b0, cnt_i} + {2'b00, cfg_i.la}) >= beat_len);
  assign lane_on        = cs_o && (wr_i || cfg_i.lm) && (cs_age_i >= cfg_i.ld)
                       && !lane_early_off;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign wbe_o[g] = lane_on && be_i[g];
  end

  logic unused_cfg;
  assign unused_cfg = ^{cfg_i.cd, cfg_i.hc, cfg_i.re, cfg_i.se};

endmodule

// File: rtl/ebus_err_log.sv
`timescale 1ns/1ps
module ebus_err_log #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              clr_i,
  output logic              pulse_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      wr_o    <= 1'b0;
    end else begin
      pulse_o <= hit_i;
      if (hit_i) begin
        valid_o <= 1'b1;
        addr_o  <= addr_i;
        wr_o    <= wr_i;
      end else if (clr_i) begin
        valid_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
  import ebus_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 4,
  parameter int TMO_W  = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_burst_i,
  input  logic [BEAT_W-1:0] req_beats_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic              rdy_i,
  input  logic              tmo_en_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              err_clr_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              cs_o,
  output logic              oe_o,
  output logic [BE_W-1:0]   wbe_o,
  output logic              addr_phase_o,
  output logic              hold_phase_o,
  output logic              cap_o,
  output logic              err_pulse_o,
  output logic              err_valid_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic              err_wr_o,
  output logic              cfg_err_o
);

  tcfg_t             cfg_new, cfg_live;
  seq_st_t           st;
  logic [2:0]        cnt;
  logic              last_beat;
  logic [1:0]        cs_age;
  logic [BE_W-1:0]   be;
  logic              tmo_hit;

  ebus_cfg_unpack u_cfg (
    .word_i (cfg_word_i),
    .cfg_o  (cfg_new),
    .err_o  (cfg_err_o)
  );

  ebus_seq_fsm #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BE_W (BE_W),
    .BEAT_W (BEAT_W), .TMO_W  (TMO_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_wr_i    (req_wr_i),
    .req_be_i    (req_be_i),
    .req_wdata_i (req_wdata_i),
    .req_burst_i (req_burst_i),
    .req_beats_i (req_beats_i),
    .cfg_i       (cfg_new),
    .rdy_i       (rdy_i),
    .tmo_en_i    (tmo_en_i),
    .tmo_limit_i (tmo_limit_i),
    .st_o        (st),
    .cnt_o       (cnt),
    .last_beat_o (last_beat),
    .cs_age_o    (cs_age),
    .lcfg_o      (cfg_live),
    .addr_o      (bus_addr_o),
    .wr_o        (bus_wr_o),
    .be_o        (be),
    .wdata_o     (bus_wdata_o),
    .cap_o       (cap_o),
    .tmo_hit_o   (tmo_hit)
  );

  ebus_strobe_gen #(.BE_W (BE_W)) u_strb (
    .st_i         (st),
    .cnt_i        (cnt),
    .last_beat_i  (last_beat),
    .cs_age_i     (cs_age),
    .cfg_i        (cfg_live),
    .wr_i         (bus_wr_o),
    .be_i         (be),
    .cs_o         (cs_o),
    .oe_o         (oe_o),
    .wbe_o        (wbe_o),
    .addr_phase_o (addr_phase_o),
    .hold_phase_o (hold_phase_o)
  );

  ebus_err_log #(.ADDR_W (ADDR_W)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (tmo_hit),
    .addr_i  (bus_addr_o),
    .wr_i    (bus_wr_o),
    .clr_i   (err_clr_i),
    .pulse_o (err_pulse_o),
    .valid_o (err_valid_o),
    .addr_o  (err_addr_o),
    .wr_o    (err_wr_o)
  );

endmodule

// File: rtl/ebus_seq_chk.sv
`timescale 1ns/1ps
module ebus_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              bus_wr_o,
  input logic              cs_o,
  input logic              oe_o,
  input logic [BE_W-1:0]   wbe_o,
  input logic              addr_phase_o,
  input logic              hold_phase_o,
  input logic              cap_o,
  input logic              err_pulse_o,
  input logic              err_valid_o,
  input logic [ADDR_W-1:0] err_addr_o,
  input logic              err_clr_i
);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o |=> addr_phase_o && !req_ready_o);

  p_oe_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> cs_o && !bus_wr_o);

  p_lanes_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wbe_o != '0) |-> cs_o);

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_phase_o |-> addr_phase_o && !cs_o && !oe_o && (wbe_o == '0));

  p_cap_inside_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> cs_o);

  p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |=> !err_pulse_o);

  p_err_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_o |-> err_valid_o);

  p_err_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid_o && !err_clr_i |=> err_valid_o && (err_pulse_o || $stable(err_addr_o)));

endmodule

bind ebus_seq ebus_seq_chk #(.ADDR_W (ADDR_W), .BE_W (BE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .bus_wr_o     (bus_wr_o),
  .cs_o         (cs_o),
  .oe_o         (oe_o),
  .wbe_o        (wbe_o),
  .addr_phase_o (addr_phase_o),
  .hold_phase_o (hold_phase_o),
  .cap_o        (cap_o),
  .err_pulse_o  (err_pulse_o),
  .err_valid_o  (err_valid_o),
  .err_addr_o   (err_addr_o),
  .err_clr_i    (err_clr_i)
);

// File: tb/ebus_seq_bench.sv
`timescale 1ns/1ps
module ebus_seq_bench;

  localparam int NTR   = 48;
  localparam int NEVER = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        req_wr = 1'b0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = 32'h1234_5678;
  logic        req_burst = 1'b0;
  logic [3:0]  req_beats = '0;
  logic [31:0] cfg_word = '0;
  logic        rdy = 1'b0, tmo_en = 1'b0, err_clr = 1'b0;
  logic [7:0]  tmo_limit = '0;
  logic [31:0] bus_addr, bus_wdata, err_addr;
  logic        bus_wr, cs, oe, addr_phase, hold_phase, cap;
  logic        err_pulse, err_valid, err_wr, cfg_err;
  logic [3:0]  wbe;

  always #2.5 clk = ~clk;

  ebus_seq u_ebus_seq (
    .clk (clk), .rst_n (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_addr_i (req_addr), .req_wr_i (req_wr), .req_be_i (req_be),
    .req_wdata_i (req_wdata), .req_burst_i (req_burst), .req_beats_i (req_beats),
    .cfg_word_i (cfg_word), .rdy_i (rdy), .tmo_en_i (tmo_en),
    .tmo_limit_i (tmo_limit), .err_clr_i (err_clr),
    .bus_addr_o (bus_addr), .bus_wr_o (bus_wr), .bus_wdata_o (bus_wdata),
    .cs_o (cs), .oe_o (oe), .wbe_o (wbe), .addr_phase_o (addr_phase),
    .hold_phase_o (hold_phase), .cap_o (cap), .err_pulse_o (err_pulse),
    .err_valid_o (err_valid), .err_addr_o (err_addr), .err_wr_o (err_wr),
    .cfg_err_o (cfg_err)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [NTR-1:0] tr_cs, tr_oe, tr_wbe, tr_hold, tr_av, tr_cap, tr_err, tr_rr;
  logic [31:0]    tr_addr [NTR];
  logic [3:0]     tr_wbev [NTR];

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // LSB-0 placement of the fields listed in R2
  function automatic logic [31:0] mk_cfg(input int bw, input int cd, input int od,
      input int ld, input int la, input int hc, input int re, input int se, input int lm);
    logic [31:0] w;
    w = '0;
    w[25:23] = bw[2:0];
    w[19:18] = cd[1:0];
    w[17:16] = od[1:0];
    w[15:14] = ld[1:0];
    w[13:12] = la[1:0];
    w[11:9]  = hc[2:0];
    w[8]     = re[0];
    w[7]     = se[0];
    w[6]     = lm[0];
    return w;
  endfunction

  function automatic int first1(input logic [NTR-1:0] v);
    for (int i = 0; i < NTR; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int last1(input logic [NTR-1:0] v);
    for (int i = NTR - 1; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  task automatic run_access(input logic [31:0] cfg, input bit wr, input bit burst,
      input int beats_m1, input logic [31:0] addr, input logic [3:0] be,
      input int rdy_from, input bit ten, input int lim);
    @(negedge clk);
    cfg_word  = cfg;   req_wr    = wr;  req_burst = burst;
    req_beats = beats_m1[3:0]; req_addr = addr; req_be = be;
    tmo_en    = ten;   tmo_limit = lim[7:0]; rdy = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < NTR; k++) begin
      #1;
      req_valid = 1'b0;
      rdy = (k >= rdy_from);
      @(negedge clk);
      tr_cs[k] = cs;   tr_oe[k] = oe;   tr_wbe[k] = (wbe != 4'h0);
      tr_hold[k] = hold_phase; tr_av[k] = addr_phase; tr_cap[k] = cap;
      tr_err[k] = err_pulse; tr_rr[k] = req_ready;
      tr_addr[k] = bus_addr; tr_wbev[k] = wbe;
      @(posedge clk);
    end
    #1 rdy = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset addr phase", int'(addr_phase), 0);
    chk("R3 reset cs", int'(cs), 0);
    chk("R12 reset err valid", int'(err_valid), 0);
  endtask

  task automatic t_basic_read();
    run_access(mk_cfg(3, 2, 1, 0, 0, 2, 0, 0, 0), 1'b0, 1'b0, 0, 32'h40, 4'hF, NEVER, 1'b0, 0);
    chk("R2 R3 cs first", first1(tr_cs), 2);
    chk("R7 cs length", $countones(tr_cs), 4);
    chk("R4 oe first", first1(tr_oe), 3);
    chk("R4 oe last", last1(tr_oe), 5);
    chk("R5 no lanes on read LM=0", $countones(tr_wbe), 0);
    chk("R8 hold first", first1(tr_hold), 6);
    chk("R8 hold length", $countones(tr_hold), 2);
    chk("R1 addr phase length", $countones(tr_av), 8);
    chk("R1 busy ready low", $countones(~tr_rr & tr_av), 8);
    chk("R9 cap index", first1(tr_cap), 5);
  endtask

  task automatic t_burst_write();
    run_access(mk_cfg(2, 1, 0, 1, 1, 0, 0, 0, 0), 1'b1, 1'b1, 2, 32'h100, 4'hA, NEVER, 1'b0, 0);
    chk("R7 burst cs first", first1(tr_cs), 1);
    chk("R7 burst cs last", last1(tr_cs), 9);
    chk("R7 burst cs held", $countones(tr_cs), 9);
    chk("R5 lanes first", first1(tr_wbe), 2);
    chk("R6 lanes last", last1(tr_wbe), 8);
    chk("R5 lane value", int'(tr_wbev[5]), 32'hA);
    chk("R7 beat2 addr", int'(tr_addr[4]), 32'h104);
    chk("R7 beat3 addr", int'(tr_addr[7]), 32'h108);
    chk("R9 burst caps", $countones(tr_cap), 3);
    chk("R9 last cap", last1(tr_cap), 9);
    chk("R4 no oe on write", $countones(tr_oe), 0);
    chk("R8 no hold HC=0", $countones(tr_hold), 0);
  endtask

  task automatic t_burst_off();
    run_access(mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0), 1'b1, 1'b0, 2, 32'h200, 4'hF, NEVER, 1'b0, 0);
    chk("R7 no burst single beat", $countones(tr_cs), 2);
    chk("R6 lanes drop with cs LA=0", last1(tr_wbe), 1);
  endtask

  task automatic t_lane_mode_read();
    run_access(mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 1), 1'b0, 1'b0, 0, 32'h300, 4'h5, NEVER, 1'b0, 0);
    chk("R5 LM=1 read lanes first", first1(tr_wbe), 0);
    chk("R5 LM=1 read lanes count", $countones(tr_wbe), 2);
    chk("R5 LM=1 lane value", int'(tr_wbev[0]), 5);
  endtask

  task automatic t_ready_ignored();
    run_access(mk_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0), 1'b0, 1'b0, 0, 32'h10, 4'hF, NEVER, 1'b1, 1);
    chk("R9 ready ignored cs", $countones(tr_cs), 2);
    chk("R9 ready ignored cap", first1(tr_cap), 1);
    chk("R9 ready ignored no err", $countones(tr_err), 0);
  endtask

  task automatic t_ready_same_edge();
    run_access(mk_cfg(1, 0, 0, 0, 0, 1, 1, 1, 0), 1'b0, 1'b0, 0, 32'h20, 4'hF, 4, 1'b0, 0);
    chk("R10 SE=1 cap index", first1(tr_cap), 4);
    chk("R10 SE=1 cap count", $countones(tr_cap), 1);
    chk("R10 SE=1 cs last", last1(tr_cs), 4);
    chk("R8 hold after ready", first1(tr_hold), 5);
  endtask

  task automatic t_ready_late();
    run_access(mk_cfg(1, 0, 0, 0, 0, 0, 1, 0, 0), 1'b0, 1'b0, 0, 32'h24, 4'hF, 4, 1'b0, 0);
    chk("R10 SE=0 cap index", first1(tr_cap), 5);
    chk("R10 SE=0 cs last", last1(tr_cs), 5);
  endtask

  task automatic t_ready_early();
    run_access(mk_cfg(2, 0, 0, 0, 0, 1, 1, 1, 0), 1'b0, 1'b0, 0, 32'h28, 4'hF, 0, 1'b0, 0);
    chk("R10 early ready keeps wait", first1(tr_cap), 2);
    chk("R10 early ready cs", $countones(tr_cs), 3);
  endtask

  task automatic t_timeout_read();
    run_access(mk_cfg(1, 0, 0, 0, 0, 1, 1, 1, 0), 1'b0, 1'b0, 0, 32'h2A0, 4'hF, NEVER, 1'b1, 3);
    chk("R11 timeout cs last", last1(tr_cs), 4);
    chk("R11 timeout no cap", $countones(tr_cap), 0);
    chk("R11 err pulse index", first1(tr_err), 5);
    chk("R11 err pulse count", $countones(tr_err), 1);
    chk("R11 hold after timeout", first1(tr_hold), 5);
    chk("R11 err addr", int'(err_addr), 32'h2A0);
    chk("R11 err dir read", int'(err_wr), 0);
    repeat (3) @(negedge clk);
    chk("R12 err kept valid", int'(err_valid), 1);
    chk("R12 err addr kept", int'(err_addr), 32'h2A0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R12 err cleared", int'(err_valid), 0);
  endtask

  task automatic t_timeout_write();
    run_access(mk_cfg(1, 0, 0, 0, 0, 0, 1, 0, 0), 1'b1, 1'b0, 0, 32'h3C0, 4'hF, NEVER, 1'b1, 0);
    chk("R11 limit 0 pulse index", first1(tr_err), 3);
    chk("R11 limit 0 cs last", last1(tr_cs), 2);
    chk("R11 err dir write", int'(err_wr), 1);
    chk("R11 err addr write", int'(err_addr), 32'h3C0);
  endtask

  task automatic t_no_timeout();
    run_access(mk_cfg(1, 0, 0, 0, 0, 1, 1, 1, 0), 1'b0, 1'b0, 0, 32'h44, 4'hF, 20, 1'b0, 3);
    chk("R11 unlimited wait cap", first1(tr_cap), 20);
    chk("R11 unlimited wait no err", $countones(tr_err), 0);
  endtask

  task automatic t_cfg_err();
    @(negedge clk);
    cfg_word = mk_cfg(1, 0, 0, 0, 2, 1, 0, 0, 0);
    #1 chk("R13 advance over wait", int'(cfg_err), 1);
    cfg_word = mk_cfg(3, 0, 0, 0, 1, 1, 1, 0, 0);
    #1 chk("R13 advance with ready", int'(cfg_err), 1);
    cfg_word = mk_cfg(3, 0, 0, 0, 0, 0, 1, 1, 0);
    #1 chk("R13 no hold same edge", int'(cfg_err), 1);
    cfg_word = mk_cfg(3, 1, 1, 1, 3, 0, 0, 1, 1);
    #1 chk("R13 legal word", int'(cfg_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic_read();
    t_burst_write();
    t_burst_off();
    t_lane_mode_read();
    t_ready_ignored();
    t_ready_same_edge();
    t_ready_late();
    t_ready_early();
    t_timeout_read();
    t_timeout_write();
    t_no_timeout();
    t_cfg_err();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule